// File: doc/BRIEF.md
# Interrupt-Gated DMA Request Controller

This block raises the playback and capture DMA request lines of an audio codec and keeps a down-counter of sample periods. Each request is a level that goes high on a sample tick while its channel is enabled. It stays high until the host DMA engine acknowledges it. The counter steps down once per sample tick while either channel is enabled. When the counter is zero at a tick, it reloads from a base value and gives a one-cycle expiry pulse. Host logic uses that pulse to set a sticky interrupt flag, which comes back in as an input.

When the transfer-hold option is set and the interrupt flag is pending, the block is stalled. In a stall it raises no new requests, freezes the counter and reports no FIFO errors. A request already raised stays up until it is acknowledged. The FIFO keeps draining at the sample rate. The block sees FIFO occupancy only as a level input. The block also picks the DAC data source on each tick. Once the playback FIFO is empty, the DACs get either midscale or a repeat of the last valid sample, as chosen by a fill option.

Clearing either the interrupt flag or the hold option ends the stall. Requests then resume on the next tick for every enabled channel.

Top module: `dma_req_gate`

## Requirements
- R1: Synchronous reset clears both requests, the expiry pulse and both error flags. It loads the counter with `cnt_base` and sets `dac_src` to 0 (FIFO).
- R2: While not stalled, a tick with a channel enabled sets that channel's request in the next cycle, whatever the interrupt flag is when hold is clear. Stalled means `xfer_hold` and `irq_flag` are both 1.
- R3: A raised request stays high until its acknowledge is sampled. An acknowledge drops it in the next cycle unless a new request is raised in the same cycle.
- R4: While stalled, a tick raises no new request.
- R5: When not stalled and either channel is enabled, a tick decrements the counter. If the counter is already zero, the tick instead reloads `cnt_base` and pulses `cnt_expire` for one cycle.
- R6: The counter holds its value without a tick, with both channels disabled, or while stalled.
- R7: On each tick `dac_src` is updated. It becomes 0 (FIFO) when `pb_lvl` is nonzero. With an empty FIFO it becomes 1 (midscale) if `dac_zero` is set and 2 (repeat last sample) otherwise. Between ticks it holds.
- R8: `pb_underrun` pulses for one cycle after a non-stalled tick with playback enabled and `pb_lvl` equal to 0.
- R9: `cap_overrun` pulses for one cycle after a non-stalled tick with capture enabled and `cap_lvl` equal to `FIFO_DEPTH`.
- R10: No underrun or overrun pulse follows a tick taken while stalled.
- R11: Clearing either `irq_flag` or `xfer_hold` lets the next tick raise requests for every enabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle sample-period strobe |
| pb_en | input | 1 | Playback channel enable |
| cap_en | input | 1 | Capture channel enable |
| xfer_hold | input | 1 | Block transfers while the interrupt is pending |
| irq_flag | input | 1 | Sticky interrupt status |
| dac_zero | input | 1 | Fill choice for an empty FIFO: 1 midscale, 0 repeat |
| pb_ack | input | 1 | Host acknowledge of the playback request |
| cap_ack | input | 1 | Host acknowledge of the capture request |
| pb_lvl | input | LVL_W | Playback FIFO occupancy |
| cap_lvl | input | LVL_W | Capture FIFO occupancy |
| cnt_base | input | CNT_W | Counter reload value |
| pb_req | output | 1 | Playback DMA request |
| cap_req | output | 1 | Capture DMA request |
| cnt_val | output | CNT_W | Sample counter value |
| cnt_expire | output | 1 | One-cycle pulse on counter reload |
| dac_src | output | 2 | DAC source: 0 FIFO, 1 midscale, 2 repeat |
| pb_underrun | output | 1 | Playback underrun pulse |
| cap_overrun | output | 1 | Capture overrun pulse |

## Verification
The bench goes after three kinds of corner case.

The first is a tick and an acknowledge in the same cycle. A design that let the acknowledge win would drop a fresh request and stall the DMA. The second is a stall that begins while a request is still pending. A design that flushed the pending request there would lose a transfer, and one that kept counting or flagging errors would show a drifting counter or a false underrun. The third is the counter at zero and the two FIFO extremes, empty and full. A wrong reload would skip or repeat an expiry pulse, and a wrong fill would send midscale where the last sample belongs.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    SRC_FIFO = 2'd0,
    SRC_MID  = 2'd1,
    SRC_HOLD = 2'd2
  } dac_src_t;
endpackage

// File: rtl/dma_chan_req.sv
module dma_chan_req #(
  parameter int  DEPTH  = 16,
  parameter int  LVL_W  = $clog2(DEPTH + 1),
  parameter bit  IS_CAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             stall,
  input  logic             ack,
  input  logic [LVL_W-1:0] lvl,
  output logic             req,
  output logic             err
);
  logic lvl_edge;
  logic go;

  // capture fails when full, playback when empty
  generate
    if (IS_CAP) begin : g_cap
      assign lvl_edge = (lvl == LVL_W'(DEPTH));
    end else begin : g_pb
      assign lvl_edge = (lvl == '0);
    end
  endgenerate

  assign go = tick & en & ~stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      err <= 1'b0;
    end else begin
      if (go)       req <= 1'b1;   // a new request beats a same-cycle ack
      else if (ack) req <= 1'b0;
      err <= go & lvl_edge;
    end
  end
endmodule

// File: rtl/dma_smp_count.sv
module dma_smp_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             stall,
  input  logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= base;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (tick && run && !stall) begin
        if (cnt == '0) begin
          cnt    <= base;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_dac_fill.sv
module dma_dac_fill
  import dma_req_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dac_zero,
  input  logic [LVL_W-1:0] lvl,
  output dac_src_t         src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src <= SRC_FIFO;
    end else if (tick) begin
      if (lvl != '0)    src <= SRC_FIFO;
      else if (dac_zero) src <= SRC_MID;
      else               src <= SRC_HOLD;
    end
  end
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_req_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_tick,
  input  logic             pb_en,
  input  logic             cap_en,
  input  logic             xfer_hold,
  input  logic             irq_flag,
  input  logic             dac_zero,
  input  logic             pb_ack,
  input  logic             cap_ack,
  input  logic [LVL_W-1:0] pb_lvl,
  input  logic [LVL_W-1:0] cap_lvl,
  input  logic [CNT_W-1:0] cnt_base,
  output logic             pb_req,
  output logic             cap_req,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_expire,
  output logic [1:0]       dac_src,
  output logic             pb_underrun,
  output logic             cap_overrun
);
  localparam int NCH = 2;

  logic             stall;
  logic [NCH-1:0]   en_v, ack_v, req_v, err_v;
  logic [LVL_W-1:0] lvl_v [NCH];
  dac_src_t         src_q;

  assign stall    = xfer_hold & irq_flag;
  assign en_v     = {cap_en, pb_en};
  assign ack_v    = {cap_ack, pb_ack};
  assign lvl_v[0] = pb_lvl;
  assign lvl_v[1] = cap_lvl;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_chan_req #(
        .DEPTH (FIFO_DEPTH),
        .LVL_W (LVL_W),
        .IS_CAP(i == 1)
      ) u_ch (
        .clk  (clk),
        .rst  (rst),
        .tick (smp_tick),
        .en   (en_v[i]),
        .stall(stall),
        .ack  (ack_v[i]),
        .lvl  (lvl_v[i]),
        .req  (req_v[i]),
        .err  (err_v[i])
      );
    end
  endgenerate

  dma_smp_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (smp_tick),
    .run   (pb_en | cap_en),
    .stall (stall),
    .base  (cnt_base),
    .cnt   (cnt_val),
    .expire(cnt_expire)
  );

  dma_dac_fill #(.LVL_W(LVL_W)) u_fill (
    .clk     (clk),
    .rst     (rst),
    .tick    (smp_tick),
    .dac_zero(dac_zero),
    .lvl     (pb_lvl),
    .src     (src_q)
  );

  assign pb_req      = req_v[0];
  assign cap_req     = req_v[1];
  assign pb_underrun = err_v[0];
  assign cap_overrun = err_v[1];
  assign dac_src     = src_q;
endmodule

// File: rtl/dma_req_gate_chk.sv
module dma_req_gate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_tick,
  input logic             pb_en,
  input logic             cap_en,
  input logic             xfer_hold,
  input logic             irq_flag,
  input logic             pb_ack,
  input logic             cap_ack,
  input logic             pb_req,
  input logic             cap_req,
  input logic [CNT_W-1:0] cnt_val,
  input logic             pb_underrun,
  input logic             cap_overrun,
  input logic [1:0]       dac_src
);
  // R3: a pending request without an ack stays up
  p_pb_pending_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pb_req) && !$past(pb_ack)) |-> pb_req);
  p_cap_pending_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cap_req) && !$past(cap_ack)) |-> cap_req);

  // R4: a request only rises after an unstalled tick with its enable
  p_pb_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(pb_req)) |->
      $past(smp_tick && pb_en && !(xfer_hold && irq_flag)));
  p_cap_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(cap_req)) |->
      $past(smp_tick && cap_en && !(xfer_hold && irq_flag)));

  // R6: counter frozen during a stall
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xfer_hold && irq_flag)) |-> $stable(cnt_val));

  // R10: no error reporting during a stall
  p_no_err_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xfer_hold && irq_flag)) |-> (!pb_underrun && !cap_overrun));

  // R7: only the three defined source codes appear
  p_src_legal_r7: assert property (@(posedge clk) disable iff (rst)
    dac_src != 2'd3);
endmodule

bind dma_req_gate dma_req_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .smp_tick(smp_tick), .pb_en(pb_en), .cap_en(cap_en),
  .xfer_hold(xfer_hold), .irq_flag(irq_flag), .pb_ack(pb_ack), .cap_ack(cap_ack),
  .pb_req(pb_req), .cap_req(cap_req), .cnt_val(cnt_val),
  .pb_underrun(pb_underrun), .cap_overrun(cap_overrun), .dac_src(dac_src)
);

// File: tb/test_dma_req_gate.sv
module test_dma_req_gate;
  localparam int CNT_W = 16;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] BASE = 16'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_tick = 0, pb_en = 0, cap_en = 0, xfer_hold = 0, irq_flag = 0;
  logic dac_zero = 0, pb_ack = 0, cap_ack = 0;
  logic [LVL_W-1:0] pb_lvl = '0, cap_lvl = '0;
  logic [CNT_W-1:0] cnt_base = BASE;
  logic pb_req, cap_req, cnt_expire, pb_underrun, cap_overrun;
  logic [CNT_W-1:0] cnt_val;
  logic [1:0] dac_src;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected state
  logic e_pb, e_cap, e_exp, e_un, e_ov;
  logic [CNT_W-1:0] e_cnt;
  logic [1:0] e_src;

  always #10 clk = ~clk;

  dma_req_gate #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) i_dma_req_gate (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .pb_en(pb_en), .cap_en(cap_en),
    .xfer_hold(xfer_hold), .irq_flag(irq_flag), .dac_zero(dac_zero),
    .pb_ack(pb_ack), .cap_ack(cap_ack), .pb_lvl(pb_lvl), .cap_lvl(cap_lvl),
    .cnt_base(cnt_base), .pb_req(pb_req), .cap_req(cap_req), .cnt_val(cnt_val),
    .cnt_expire(cnt_expire), .dac_src(dac_src), .pb_underrun(pb_underrun),
    .cap_overrun(cap_overrun));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] fill_src(logic [LVL_W-1:0] lvl, logic dz);
    if (lvl != '0) return 2'd0;
    return dz ? 2'd1 : 2'd2;
  endfunction

  // advance one clock, update the model, compare all outputs
  task automatic step();
    logic stall, go_pb, go_cap;
    stall  = xfer_hold & irq_flag;
    go_pb  = smp_tick & pb_en & ~stall;
    go_cap = smp_tick & cap_en & ~stall;
    if (rst) begin
      e_pb = 0; e_cap = 0; e_exp = 0; e_un = 0; e_ov = 0; e_cnt = cnt_base; e_src = 2'd0;
    end else begin
      e_pb  = go_pb  ? 1'b1 : (pb_ack  ? 1'b0 : e_pb);
      e_cap = go_cap ? 1'b1 : (cap_ack ? 1'b0 : e_cap);
      e_un  = go_pb  && (pb_lvl == '0);
      e_ov  = go_cap && (cap_lvl == LVL_W'(DEPTH));
      e_exp = 1'b0;
      if (smp_tick && (pb_en || cap_en) && !stall) begin
        if (e_cnt == '0) begin e_cnt = cnt_base; e_exp = 1'b1; end
        else e_cnt = e_cnt - 1'b1;
      end
      if (smp_tick) e_src = fill_src(pb_lvl, dac_zero);
    end
    @(posedge clk);
    #2;
    chk("R2/R3/R4 pb_req", 32'(pb_req), 32'(e_pb));
    chk("R2/R3/R4 cap_req", 32'(cap_req), 32'(e_cap));
    chk("R5/R6 cnt_val", 32'(cnt_val), 32'(e_cnt));
    chk("R5 cnt_expire", 32'(cnt_expire), 32'(e_exp));
    chk("R7 dac_src", 32'(dac_src), 32'(e_src));
    chk("R8/R10 pb_underrun", 32'(pb_underrun), 32'(e_un));
    chk("R9/R10 cap_overrun", 32'(cap_overrun), 32'(e_ov));
  endtask

  task automatic idle();
    smp_tick = 0; pb_ack = 0; cap_ack = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1;
    step(); step();
    // R1: reset state
    chk("R1 pb_req", 32'(pb_req), 0);
    chk("R1 cap_req", 32'(cap_req), 0);
    chk("R1 cnt_val", 32'(cnt_val), 32'(BASE));
    chk("R1 dac_src", 32'(dac_src), 0);
    rst = 0;
    step();

    // R2: hold clear, irq set -> still raises
    pb_en = 1; cap_en = 1; irq_flag = 1; pb_lvl = 5'd3; cap_lvl = 5'd2; smp_tick = 1;
    step(); idle();
    chk("R2 pb_req with irq", 32'(pb_req), 1);
    // R3: tick + ack same cycle keeps request
    smp_tick = 1; pb_ack = 1; step(); idle();
    chk("R3 tick beats ack", 32'(pb_req), 1);
    // stall with pending request: R3 hold, R4 no new, R6, R10
    xfer_hold = 1; pb_lvl = '0; cap_lvl = 5'(DEPTH);
    smp_tick = 1; step(); idle();
    chk("R3 pending held in stall", 32'(pb_req), 1);
    chk("R10 no underrun in stall", 32'(pb_underrun), 0);
    pb_ack = 1; cap_ack = 1; step(); idle();
    chk("R3 ack drops", 32'(pb_req), 0);
    dac_zero = 1; smp_tick = 1; step(); idle();
    chk("R4 no raise in stall", 32'(cap_req), 0);
    chk("R7 midscale when empty", 32'(dac_src), 1);
    // R11: clear irq, resume; empty and full produce errors
    irq_flag = 0; smp_tick = 1; step(); idle();
    chk("R11 pb resume", 32'(pb_req), 1);
    chk("R11 cap resume", 32'(cap_req), 1);
    chk("R8 underrun", 32'(pb_underrun), 1);
    chk("R9 overrun", 32'(cap_overrun), 1);
    step();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      smp_tick = ($urandom_range(1) == 0);
      pb_ack   = ($urandom_range(2) == 0);
      cap_ack  = ($urandom_range(2) == 0);
      if ($urandom_range(15) == 0) pb_en = ~pb_en;
      if ($urandom_range(15) == 0) cap_en = ~cap_en;
      if ($urandom_range(7) == 0)  irq_flag = ~irq_flag;
      if ($urandom_range(11) == 0) xfer_hold = ~xfer_hold;
      if ($urandom_range(9) == 0)  dac_zero = ~dac_zero;
      case ($urandom_range(3))
        0: pb_lvl = '0;
        1: pb_lvl = 5'(DEPTH);
        default: pb_lvl = 5'($urandom_range(DEPTH));
      endcase
      case ($urandom_range(3))
        0: cap_lvl = '0;
        1: cap_lvl = 5'(DEPTH);
        default: cap_lvl = 5'($urandom_range(DEPTH));
      endcase
      if ($urandom_range(499) == 0) rst = 1; else rst = 0;
      step();
    end
    rst = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule